// File: doc/BRIEF.md
# Flash Command Microsequencer

This block runs short programs that describe a serial-flash transaction. The programs sit in a small lookup table. Each 32-bit table word holds two 16-bit instructions, and each program occupies four consecutive words, which gives eight instruction slots. A start request names a program and says where the request came from: a register-driven (host) request or a memory-mapped read/write. The sequencer then walks the slots one per clock. For each phase instruction it emits one micro-operation: the phase kind, whether it runs at single or double data rate, the lane count and an 8-bit operand. A chip-select flag covers the whole transaction.

A program ends in one of four ways:
- a stop instruction;
- a jump-on-select instruction, which also saves a restart slot for a later continued request;
- running off the end of its eight slots;
- an illegal instruction, which aborts the run.

An abort reports a 4-bit error code and the index of the program that failed. Serialising bits onto pins, strobe sampling and data buffering belong to the blocks that consume the micro-operations.

Top module: `lutseq_top`

## Requirements
- R1: A table write stores `tblWrData` at word `tblWrAddr`. Program `p` occupies words `4p` to `4p+3`. Within a word, bits [15:0] hold the even slot and bits [31:16] the odd slot. Each instruction is laid out as opcode [15:10], pad code [9:8] and operand [7:0]. Reset clears every word to zero, so an unwritten program stops at once.
- R2: A start request seen while idle makes `busy` high on the next cycle. After that the block handles one slot per cycle, and the result of slot k appears k+1 cycles after `busy` rises. At most one of `opValid`, `seqDone` and `errValid` is high in any cycle.
- R3: A phase opcode is 0x01 to 0x0D (single rate) or 0x21 to 0x2D (double rate). It yields `opValid` with `opKind` equal to opcode[3:0], `opDdr` equal to opcode[5], `opLanes` equal to 1 shifted left by the pad code (pad 0 to 3 gives 1, 2, 4 or 8 lanes) and `opOperand` equal to the operand.
- R4: Opcode 0x00 ends the run. It pulses `seqDone` for one cycle, drops `csActive` and `busy`, and emits no micro-operation.
- R5: A program with no stop ends after its eighth slot, with a `seqDone` pulse in the following cycle.
- R6: Opcode 0x1F from a memory-mapped request ends the run as a stop does and saves operand[2:0] as the restart slot. A start with `startContinue` set begins at the saved slot; a start without it begins at slot 0. Reset sets the saved slot to 0.
- R7: Any opcode that is not 0x00, 0x1F or a phase opcode aborts the run with error code 0x3.
- R8: The rate of a run is the rate of its first executed instruction. Opcode 0x0C or 0x0D in a double-rate run aborts with code 0x4. Opcode 0x2C or 0x2D in a single-rate run aborts with code 0x5.
- R9: Opcode 0x1F in a host-register request (`startIsIp`=1) aborts with code 0x2 and leaves the saved slot unchanged.
- R10: An abort pulses `errValid` for one cycle. It loads `errCode` and `errSeq` (the program index), which hold until the next abort. It drops `csActive` and `busy` and gives no `seqDone`.
- R11: A start request seen while `busy` is high is ignored.
- R12: `csActive` rises with the first micro-operation of a run and stays high until the run ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tblWrEn | input | 1 | Table word write enable |
| tblWrAddr | input | 6 | Table word address |
| tblWrData | input | 32 | Table word data (two instructions) |
| startReq | input | 1 | Start a program |
| startSeq | input | 4 | Program index to start |
| startIsIp | input | 1 | 1 = host register request, 0 = memory-mapped request |
| startContinue | input | 1 | Begin at the saved restart slot |
| busy | output | 1 | A program is running |
| opValid | output | 1 | Micro-operation strobe |
| opKind | output | 4 | Phase kind (opcode[3:0]) |
| opDdr | output | 1 | Phase uses double data rate |
| opLanes | output | 4 | Lane count: 1, 2, 4 or 8 |
| opOperand | output | 8 | Instruction operand |
| csActive | output | 1 | Chip select asserted |
| seqDone | output | 1 | Normal end of run pulse |
| errValid | output | 1 | Abort pulse |
| errCode | output | 4 | Last abort code |
| errSeq | output | 4 | Program index of last abort |

## Verification
The assertions take for granted that the table is not rewritten while a program runs. This matters because each slot is decoded straight from the stored word, so a write during a run could change an instruction between slots. They also take for granted that a continued start only follows a completed jump, or relies on the reset value of the restart slot. The stimulus keeps within both: every table write happens while `busy` is low, and each scenario waits for the run to finish before it loads the next program. Overlapping start requests are sent only on purpose, to show that a running program ignores them.

// File: rtl/lutseq_pkg.sv
package lutseq_pkg;

  localparam int INSTR_W = 16;
  localparam int OPC_W   = 6;

  localparam logic [OPC_W-1:0] OPC_STOP = 6'h00;
  localparam logic [OPC_W-1:0] OPC_JUMP = 6'h1F;

  localparam logic [3:0] ERR_JUMP_HOST = 4'h2;
  localparam logic [3:0] ERR_BAD_OPC   = 4'h3;
  localparam logic [3:0] ERR_SDR_DUMMY = 4'h4;
  localparam logic [3:0] ERR_DDR_DUMMY = 4'h5;

  typedef enum logic {ST_IDLE, ST_RUN} seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       loadStart;
    logic       emitOp;
    logic       finish;
    logic       raiseErr;
    logic [3:0] errCode;
    logic       savePtr;
  } seqCtl_t;

  function automatic logic isPhaseOpc(input logic [OPC_W-1:0] opc);
    return (opc[4] == 1'b0) && (opc[3:0] >= 4'd1) && (opc[3:0] <= 4'd13);
  endfunction

  function automatic logic isDummyOpc(input logic [OPC_W-1:0] opc);
    return (opc[4] == 1'b0) && ((opc[3:0] == 4'd12) || (opc[3:0] == 4'd13));
  endfunction

endpackage

// File: rtl/lutseq_datapath.sv
module lutseq_datapath
  import lutseq_pkg::*;
#(
  parameter int NUM_SEQ = 16,
  localparam int SEQ_W   = $clog2(NUM_SEQ),
  localparam int WADDR_W = SEQ_W + 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tblWrEn,
  input  logic [WADDR_W-1:0] tblWrAddr,
  input  logic [31:0]        tblWrData,
  input  logic [SEQ_W-1:0]   startSeq,
  input  logic               startContinue,
  input  seqCtl_t            ctl,
  output logic [OPC_W-1:0]   curOpcode,
  output logic               pastEnd,
  output logic               opValid,
  output logic [3:0]         opKind,
  output logic               opDdr,
  output logic [3:0]         opLanes,
  output logic [7:0]         opOperand,
  output logic               csActive,
  output logic               seqDone,
  output logic               errValid,
  output logic [3:0]         errCode,
  output logic [SEQ_W-1:0]   errSeq
);

  localparam int WORDS = NUM_SEQ * 4;

  logic [31:0]        lutMem [WORDS];
  logic [SEQ_W-1:0]   seqReg;
  logic [3:0]         slotReg;
  logic [2:0]         savedPtr;
  logic [31:0]        rdWord;
  logic [INSTR_W-1:0] curInstr;
  logic [1:0]         curPad;
  logic [7:0]         curOperand;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < WORDS; i++) lutMem[i] <= '0;
    end else if (tblWrEn) begin
      lutMem[tblWrAddr] <= tblWrData;
    end
  end

  assign rdWord     = lutMem[{seqReg, slotReg[2:1]}];
  assign curInstr   = slotReg[0] ? rdWord[31:16] : rdWord[15:0];
  assign curOpcode  = curInstr[15:10];
  assign curPad     = curInstr[9:8];
  assign curOperand = curInstr[7:0];
  assign pastEnd    = slotReg[3];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqReg    <= '0;
      slotReg   <= '0;
      savedPtr  <= '0;
      opValid   <= 1'b0;
      opKind    <= '0;
      opDdr     <= 1'b0;
      opLanes   <= '0;
      opOperand <= '0;
      csActive  <= 1'b0;
      seqDone   <= 1'b0;
      errValid  <= 1'b0;
      errCode   <= '0;
      errSeq    <= '0;
    end else begin
      opValid  <= ctl.emitOp;
      seqDone  <= ctl.finish;
      errValid <= ctl.raiseErr;
      if (ctl.loadStart) begin
        seqReg  <= startSeq;
        slotReg <= startContinue ? {1'b0, savedPtr} : 4'd0;
      end else if (ctl.emitOp) begin
        slotReg <= slotReg + 4'd1;
      end
      if (ctl.emitOp) begin
        opKind    <= curOpcode[3:0];
        opDdr     <= curOpcode[5];
        opLanes   <= 4'b0001 << curPad;
        opOperand <= curOperand;
        csActive  <= 1'b1;
      end else if (ctl.finish || ctl.raiseErr) begin
        csActive  <= 1'b0;
      end
      if (ctl.raiseErr) begin
        errCode <= ctl.errCode;
        errSeq  <= seqReg;
      end
      if (ctl.savePtr) savedPtr <= curOperand[2:0];
    end
  end

  assert_one_event_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({opValid, seqDone, errValid}));
  assert_lanes_onehot_R3: assert property (@(posedge clk) disable iff (!rstN)
    opValid |-> $onehot(opLanes));
  assert_done_drops_cs_R4: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |-> !csActive);
  assert_err_code_legal_R7: assert property (@(posedge clk) disable iff (!rstN)
    errValid |-> (errCode inside {4'h2, 4'h3, 4'h4, 4'h5}));
  assert_err_drops_cs_R10: assert property (@(posedge clk) disable iff (!rstN)
    errValid |-> !csActive);
  assert_op_under_cs_R12: assert property (@(posedge clk) disable iff (!rstN)
    opValid |-> csActive);

endmodule

// File: rtl/lutseq_control.sv
module lutseq_control
  import lutseq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             startIsIp,
  input  logic [OPC_W-1:0] curOpcode,
  input  logic             pastEnd,
  output seqCtl_t          ctl,
  output logic             busy
);

  seqState_e state, nextState;
  logic      ddrMode;
  logic      originIp;
  logic      firstInstr;
  logic      effDdr;
  logic      dummyOpc;

  assign effDdr   = firstInstr ? curOpcode[5] : ddrMode;
  assign dummyOpc = isDummyOpc(curOpcode);
  assign busy     = (state == ST_RUN);

  always_comb begin
    ctl       = '0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (startReq) begin
          ctl.loadStart = 1'b1;
          nextState     = ST_RUN;
        end
      end
      default: begin
        nextState = ST_IDLE;
        if (pastEnd || curOpcode == OPC_STOP) begin
          ctl.finish = 1'b1;
        end else if (curOpcode == OPC_JUMP) begin
          if (originIp) begin
            ctl.raiseErr = 1'b1;
            ctl.errCode  = ERR_JUMP_HOST;
          end else begin
            ctl.finish  = 1'b1;
            ctl.savePtr = 1'b1;
          end
        end else if (!isPhaseOpc(curOpcode)) begin
          ctl.raiseErr = 1'b1;
          ctl.errCode  = ERR_BAD_OPC;
        end else if (dummyOpc && !curOpcode[5] && effDdr) begin
          ctl.raiseErr = 1'b1;
          ctl.errCode  = ERR_SDR_DUMMY;
        end else if (dummyOpc && curOpcode[5] && !effDdr) begin
          ctl.raiseErr = 1'b1;
          ctl.errCode  = ERR_DDR_DUMMY;
        end else begin
          ctl.emitOp = 1'b1;
          nextState  = ST_RUN;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      ddrMode    <= 1'b0;
      originIp   <= 1'b0;
      firstInstr <= 1'b0;
    end else begin
      state <= nextState;
      if (ctl.loadStart) begin
        originIp   <= startIsIp;
        firstInstr <= 1'b1;
      end else if (ctl.emitOp) begin
        firstInstr <= 1'b0;
        if (firstInstr) ddrMode <= curOpcode[5];
      end
    end
  end

  assert_dummy_matches_rate_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.emitOp && !firstInstr && dummyOpc) |-> (curOpcode[5] == ddrMode));
  assert_start_ignored_busy_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startReq && !ctl.finish && !ctl.raiseErr) |=> busy);

endmodule

// File: rtl/lutseq_top.sv
module lutseq_top
  import lutseq_pkg::*;
#(
  parameter int NUM_SEQ = 16,
  localparam int SEQ_W   = $clog2(NUM_SEQ),
  localparam int WADDR_W = SEQ_W + 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tblWrEn,
  input  logic [WADDR_W-1:0] tblWrAddr,
  input  logic [31:0]        tblWrData,
  input  logic               startReq,
  input  logic [SEQ_W-1:0]   startSeq,
  input  logic               startIsIp,
  input  logic               startContinue,
  output logic               busy,
  output logic               opValid,
  output logic [3:0]         opKind,
  output logic               opDdr,
  output logic [3:0]         opLanes,
  output logic [7:0]         opOperand,
  output logic               csActive,
  output logic               seqDone,
  output logic               errValid,
  output logic [3:0]         errCode,
  output logic [SEQ_W-1:0]   errSeq
);

  seqCtl_t          ctl;
  logic [OPC_W-1:0] curOpcode;
  logic             pastEnd;

  lutseq_control u_control (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .startIsIp (startIsIp),
    .curOpcode (curOpcode),
    .pastEnd   (pastEnd),
    .ctl       (ctl),
    .busy      (busy)
  );

  lutseq_datapath #(.NUM_SEQ(NUM_SEQ)) u_datapath (
    .clk           (clk),
    .rstN          (rstN),
    .tblWrEn       (tblWrEn),
    .tblWrAddr     (tblWrAddr),
    .tblWrData     (tblWrData),
    .startSeq      (startSeq),
    .startContinue (startContinue),
    .ctl           (ctl),
    .curOpcode     (curOpcode),
    .pastEnd       (pastEnd),
    .opValid       (opValid),
    .opKind        (opKind),
    .opDdr         (opDdr),
    .opLanes       (opLanes),
    .opOperand     (opOperand),
    .csActive      (csActive),
    .seqDone       (seqDone),
    .errValid      (errValid),
    .errCode       (errCode),
    .errSeq        (errSeq)
  );

endmodule

// File: tb/lutseq_top_bench.sv
module lutseq_top_bench;

  localparam int NUM_SEQ = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tblWrEn = 1'b0;
  logic [5:0]  tblWrAddr = '0;
  logic [31:0] tblWrData = '0;
  logic        startReq = 1'b0;
  logic [3:0]  startSeq = '0;
  logic        startIsIp = 1'b0;
  logic        startContinue = 1'b0;
  logic        busy, opValid, opDdr, csActive, seqDone, errValid;
  logic [3:0]  opKind, opLanes, errCode, errSeq;
  logic [7:0]  opOperand;

  lutseq_top #(.NUM_SEQ(NUM_SEQ)) u_lutseq_top (
    .clk(clk), .rstN(rstN), .tblWrEn(tblWrEn), .tblWrAddr(tblWrAddr),
    .tblWrData(tblWrData), .startReq(startReq), .startSeq(startSeq),
    .startIsIp(startIsIp), .startContinue(startContinue), .busy(busy),
    .opValid(opValid), .opKind(opKind), .opDdr(opDdr), .opLanes(opLanes),
    .opOperand(opOperand), .csActive(csActive), .seqDone(seqDone),
    .errValid(errValid), .errCode(errCode), .errSeq(errSeq)
  );

  always #5 clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  string scen = "R1 reset";
  logic [15:0] prog [8];

  // behavioural reference model
  int mMem [NUM_SEQ*4];
  int mBusy = 0, mIp = 0, mFirst = 0, mDdr = 0, mSeq = 0, mSlot = 0, mPtr = 0;
  int mOpValid = 0, mDone = 0, mErr = 0, mCs = 0;
  int mKind = 0, mOpDdr = 0, mLanes = 0, mOperand = 0, mErrCode = 0, mErrSeq = 0;

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s [%s] actual %0d expected %0d", what, scen, act, exp);
    end
  endtask

  always @(posedge clk) begin : model
    int word, ins, opc, lo, isD, effD, phase, dum, endKind, code;
    if (!rstN) begin
      foreach (mMem[i]) mMem[i] = 0;
      mBusy = 0; mPtr = 0; mCs = 0; mOpValid = 0; mDone = 0; mErr = 0;
      mErrCode = 0; mErrSeq = 0;
    end else begin
      mOpValid = 0; mDone = 0; mErr = 0; endKind = 0; code = 0;
      if (mBusy == 0) begin
        if (startReq) begin
          mBusy = 1; mSeq = startSeq; mIp = startIsIp; mFirst = 1;
          mSlot = startContinue ? mPtr : 0;
        end
      end else if (mSlot == 8) begin
        endKind = 1;
      end else begin
        word  = mMem[mSeq*4 + mSlot/2];
        ins   = (mSlot % 2 == 1) ? ((word >> 16) & 16'hFFFF) : (word & 16'hFFFF);
        opc   = ins >> 10;
        lo    = opc % 16;
        isD   = (opc >= 32) ? 1 : 0;
        phase = (((opc / 16) % 2) == 0 && lo >= 1 && lo <= 13) ? 1 : 0;
        dum   = (phase == 1 && lo >= 12) ? 1 : 0;
        effD  = mFirst ? isD : mDdr;
        if (opc == 0) endKind = 1;
        else if (opc == 31) begin
          if (mIp) begin endKind = 2; code = 2; end
          else begin mPtr = ins % 8; endKind = 1; end
        end
        else if (phase == 0) begin endKind = 2; code = 3; end
        else if (dum == 1 && isD == 0 && effD == 1) begin endKind = 2; code = 4; end
        else if (dum == 1 && isD == 1 && effD == 0) begin endKind = 2; code = 5; end
        else begin
          mOpValid = 1; mKind = lo; mOpDdr = isD; mLanes = 1 << ((ins >> 8) % 4);
          mOperand = ins % 256; mCs = 1;
          if (mFirst) mDdr = isD;
          mFirst = 0; mSlot++;
        end
      end
      if (endKind == 1) begin mDone = 1; mCs = 0; mBusy = 0; end
      if (endKind == 2) begin
        mErr = 1; mErrCode = code; mErrSeq = mSeq; mCs = 0; mBusy = 0;
      end
      if (tblWrEn) mMem[tblWrAddr] = tblWrData;
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      chk("busy R2", busy, mBusy);
      chk("opValid R2", opValid, mOpValid);
      if (mOpValid == 1) begin
        chk("opKind R3", opKind, mKind);
        chk("opDdr R3", opDdr, mOpDdr);
        chk("opLanes R3", opLanes, mLanes);
        chk("opOperand R3", opOperand, mOperand);
      end
      chk("seqDone R4", seqDone, mDone);
      chk("csActive R12", csActive, mCs);
      chk("errValid R10", errValid, mErr);
      chk("errCode R10", errCode, mErrCode);
      chk("errSeq R10", errSeq, mErrSeq);
    end
  end

  function automatic logic [15:0] mk(int opc, int pad, int opr);
    return {6'(opc), 2'(pad), 8'(opr)};
  endfunction

  task automatic clearProg();
    for (int i = 0; i < 8; i++) prog[i] = '0;
  endtask

  task automatic loadProg(int seq);
    for (int w = 0; w < 4; w++) begin
      @(negedge clk);
      tblWrEn = 1'b1; tblWrAddr = 6'(seq*4 + w);
      tblWrData = {prog[2*w+1], prog[2*w]};
    end
    @(negedge clk);
    tblWrEn = 1'b0;
  endtask

  task automatic runSeq(int seq, int ip, int cont);
    @(negedge clk);
    startReq = 1'b1; startSeq = 4'(seq); startIsIp = ip[0]; startContinue = cont[0];
    @(negedge clk);
    startReq = 1'b0;
    for (int n = 0; n < 40 && busy; n++) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    scen = "R1 empty table stops";
    runSeq(0, 0, 0);

    scen = "R3 single rate phases";
    clearProg();
    prog[0] = mk(6'h01, 0, 8'h9F); prog[1] = mk(6'h02, 2, 8'h18);
    prog[2] = mk(6'h09, 3, 8'h04); prog[3] = mk(6'h00, 0, 0);
    loadProg(1);
    runSeq(1, 1, 0);

    scen = "R3 double rate phases";
    clearProg();
    prog[0] = mk(6'h21, 3, 8'hEE); prog[1] = mk(6'h22, 3, 8'h20);
    prog[2] = mk(6'h2C, 3, 8'h06); prog[3] = mk(6'h29, 1, 8'h04);
    loadProg(2);
    runSeq(2, 0, 0);

    scen = "R5 eight slots";
    for (int i = 0; i < 8; i++) prog[i] = mk((i == 3) ? 6'h0C : 6'h08, i % 4, i + 1);
    loadProg(3);
    runSeq(3, 0, 0);

    scen = "R6 jump saves slot";
    clearProg();
    prog[0] = mk(6'h01, 0, 8'h06); prog[1] = mk(6'h1F, 0, 8'h05);
    loadProg(4);
    for (int i = 0; i < 8; i++) prog[i] = mk(6'h03, 1, 8'h40 + i);
    loadProg(5);
    runSeq(4, 0, 0);
    scen = "R6 continue at saved slot";
    runSeq(5, 0, 1);
    scen = "R6 no continue starts at zero";
    runSeq(5, 1, 0);

    scen = "R9 jump from host";
    runSeq(4, 1, 0);
    scen = "R9 saved slot kept";
    runSeq(5, 0, 1);

    scen = "R7 unknown opcode";
    clearProg();
    prog[0] = mk(6'h01, 0, 8'h05); prog[1] = mk(6'h10, 0, 0);
    loadProg(6);
    runSeq(6, 0, 0);

    scen = "R8 sdr dummy in ddr";
    clearProg();
    prog[0] = mk(6'h21, 3, 8'hA0); prog[1] = mk(6'h0C, 3, 8'h08);
    loadProg(7);
    runSeq(7, 0, 0);
    scen = "R8 ddr dummy in sdr";
    clearProg();
    prog[0] = mk(6'h01, 0, 8'hEB); prog[1] = mk(6'h2D, 2, 8'h04);
    loadProg(8);
    runSeq(8, 0, 0);
    scen = "R8 ddr dummy first then sdr dummy";
    clearProg();
    prog[0] = mk(6'h2D, 2, 8'h02); prog[1] = mk(6'h0D, 2, 8'h02);
    loadProg(9);
    runSeq(9, 1, 0);

    scen = "R11 start while busy";
    @(negedge clk);
    startReq = 1'b1; startSeq = 4'd3; startIsIp = 1'b0; startContinue = 1'b0;
    @(negedge clk);
    startReq = 1'b0;
    @(negedge clk);
    startReq = 1'b1; startSeq = 4'd7;
    @(negedge clk);
    startReq = 1'b0;
    for (int n = 0; n < 40 && busy; n++) @(negedge clk);

    scen = "R2 back to back starts";
    @(negedge clk);
    startReq = 1'b1; startSeq = 4'd1;
    @(negedge clk);
    startReq = 1'b0;
    for (int n = 0; n < 40 && busy; n++) @(negedge clk);
    startReq = 1'b1; startSeq = 4'd2;
    @(negedge clk);
    startReq = 1'b0;
    for (int n = 0; n < 40 && busy; n++) @(negedge clk);
    repeat (3) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired [%s] actual 1 expected 0", scen);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule